// File: doc/BRIEF.md
# Round-Robin Output Refresh Sequencer

This block decides when each analog output channel is refreshed from its stored code. A refresh clock, taken either from an internal divided tick or from an external pin, sets the pace. Each falling edge of that clock refreshes the channel under the pointer, and the following rising edge opens that channel's sample switch. The pointer then moves to the next channel. After the last channel it wraps to channel 0 and marks the end of a rotation.

The code handed to a channel does not jump straight to its target. It moves toward the target by at most `STEP` codes per visit, so a full-scale change spreads over several rotations. When the remaining distance is within one step, the channel lands exactly on the target. The same visit logic therefore gives single-slot latency for small changes and bounded slewing for large ones.

The clock-source choice is sampled only when a rotation completes, and the pin's output enable follows from that choice. The outputs are plain strobes toward an analog stage that cannot stall. There is no valid/ready pair and no back-pressure: every refresh event produces exactly one `sample_stb` pulse, whatever the consumer does.

Top module: `ref_refresh_seq`

## Requirements
- R1: Channels are refreshed one per refresh-clock period in the order 0, 1, …, NUM_CH-1, then wrapping to 0. `ch_idx` names the refreshed channel on each `sample_stb` pulse.
- R2: `sample_stb` pulses for one cycle per falling refresh-clock edge, and `hold_stb` pulses for one cycle per rising edge. The two never pulse in the same cycle. Within a rotation, exactly one `hold_stb` lies between two consecutive `sample_stb` pulses.
- R3: When a channel's target is more than `STEP` codes away from its presented code, the new `ch_code` is the old one moved `STEP` codes toward the target.
- R4: When the distance is at most `STEP`, the new `ch_code` equals the target exactly, with no overshoot.
- R5: `rot_done` pulses in the same cycle as the `sample_stb` for channel NUM_CH-1, and at no other time.
- R6: In reset and until the first refresh, `ch_idx` is 0, `ch_code` is 0, all strobes are low and `osc_oe` is 0. The internal tick is the selected source, and every presented code starts at 0.
- R7: With the internal source, refreshes are 2·TICK_HALF system clocks apart. With the external source, they follow the falling edges of `ext_clk_in`, which is synchronised through two flops.
- R8: `ext_sel` is taken in only at a rotation end (the `rot_done` cycle); 1 selects the external pin and 0 the internal tick. `osc_oe` changes only in that cycle and becomes the inverse of the sampled `ext_sel`.
- R9: A target written on a rotation boundary is used at each channel's next visit: channel 0 one slot later, the last channel within the same rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| target_codes | input | NUM_CH*CODE_W | Target codes, channel k in bits [k*CODE_W +: CODE_W] |
| ext_sel | input | 1 | Clock-source request: 1 external pin, 0 internal tick |
| ext_clk_in | input | 1 | External refresh clock from the pin |
| osc_out | output | 1 | Internal tick level, for driving onto the pin |
| osc_oe | output | 1 | Pin output enable for `osc_out` |
| ch_idx | output | IDX_W | Channel refreshed by the current `sample_stb` |
| ch_code | output | CODE_W | Code presented to that channel |
| sample_stb | output | 1 | One-cycle refresh pulse (falling refresh edge) |
| hold_stb | output | 1 | One-cycle switch-open pulse (rising refresh edge) |
| rot_done | output | 1 | One-cycle pulse when a rotation completes |

## Verification
The rotation end is the cycle where three things coincide: the refresh of the last channel, the `rot_done` pulse, and the takeover of a pending clock-source change together with the new `osc_oe` value. The bench raises `ext_sel` in the middle of a rotation and checks two things at the ports. First, the old source keeps its spacing for the remaining slots. Second, `osc_oe` and the slot spacing change only after the `rot_done` that carries the last channel. A scoreboard holds the step-limited code expected for every slot, so a takeover at the wrong time also shows up as a misordered or misvalued slot.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  // One refresh-clock edge event, already reduced to single-cycle pulses
  typedef struct packed {
    logic fall;
    logic rise;
  } rclk_edge_t;
endpackage

// File: rtl/rseq_tick_gen.sv
module rseq_tick_gen #(
  parameter int TICK_HALF = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 lvl,
  output rseq_pkg::rclk_edge_t edge_o
);
  localparam int CW = (TICK_HALF > 1) ? $clog2(TICK_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(TICK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      lvl         <= 1'b1;
      edge_o.fall <= 1'b0;
      edge_o.rise <= 1'b0;
    end else begin
      edge_o.fall <= wrap & lvl;
      edge_o.rise <= wrap & ~lvl;
      if (wrap) begin
        cnt <= '0;
        lvl <= ~lvl;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rseq_ext_edge.sv
module rseq_ext_edge (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin,
  output rseq_pkg::rclk_edge_t edge_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_o.fall = s3 & ~s2;
  assign edge_o.rise = ~s3 & s2;
endmodule

// File: rtl/rseq_code_stepper.sv
module rseq_code_stepper #(
  parameter int CODE_W = 10,
  parameter int STEP   = 128
) (
  input  logic [CODE_W-1:0] cur,
  input  logic [CODE_W-1:0] tgt,
  output logic [CODE_W-1:0] nxt
);
  localparam int DW = CODE_W + 1;

  logic [DW-1:0] dist_up, dist_dn;

  assign dist_up = {1'b0, tgt} - {1'b0, cur};
  assign dist_dn = {1'b0, cur} - {1'b0, tgt};

  always_comb begin
    if (tgt > cur)
      nxt = (dist_up > DW'(STEP)) ? cur + CODE_W'(STEP) : tgt;
    else if (tgt < cur)
      nxt = (dist_dn > DW'(STEP)) ? cur - CODE_W'(STEP) : tgt;
    else
      nxt = cur;
  end
endmodule

// File: rtl/ref_refresh_seq.sv
module ref_refresh_seq #(
  parameter int NUM_CH    = 12,
  parameter int CODE_W    = 10,
  parameter int STEP      = 128,
  parameter int TICK_HALF = 16,
  localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*CODE_W-1:0] target_codes,
  input  logic                     ext_sel,
  input  logic                     ext_clk_in,
  output logic                     osc_out,
  output logic                     osc_oe,
  output logic [IDX_W-1:0]         ch_idx,
  output logic [CODE_W-1:0]        ch_code,
  output logic                     sample_stb,
  output logic                     hold_stb,
  output logic                     rot_done
);
  localparam int LAST = NUM_CH - 1;

  rseq_pkg::rclk_edge_t int_e, ext_e, sel_e;

  logic              use_ext;
  logic [IDX_W-1:0]  ptr;
  logic [CODE_W-1:0] pres [NUM_CH];
  logic [CODE_W-1:0] cur_tgt, cur_pres, stepped;
  logic              at_last;

  rseq_tick_gen #(.TICK_HALF(TICK_HALF)) tick_i (
    .clk(clk), .rst_n(rst_n), .lvl(osc_out), .edge_o(int_e)
  );

  rseq_ext_edge ext_i (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk_in), .edge_o(ext_e)
  );

  // Select edges rather than levels so a source change never fakes an edge
  assign sel_e    = use_ext ? ext_e : int_e;
  assign cur_tgt  = target_codes[int'(ptr)*CODE_W +: CODE_W];
  assign cur_pres = pres[ptr];
  assign at_last  = (ptr == IDX_W'(LAST));

  rseq_code_stepper #(.CODE_W(CODE_W), .STEP(STEP)) step_i (
    .cur(cur_pres), .tgt(cur_tgt), .nxt(stepped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      use_ext    <= 1'b0;
      osc_oe     <= 1'b0;
      ch_idx     <= '0;
      ch_code    <= '0;
      sample_stb <= 1'b0;
      hold_stb   <= 1'b0;
      rot_done   <= 1'b0;
      for (int k = 0; k < NUM_CH; k++) pres[k] <= '0;
    end else begin
      sample_stb <= 1'b0;
      hold_stb   <= 1'b0;
      rot_done   <= 1'b0;
      if (sel_e.fall) begin
        pres[ptr]  <= stepped;
        ch_code    <= stepped;
        ch_idx     <= ptr;
        sample_stb <= 1'b1;
        if (at_last) begin
          ptr      <= '0;
          rot_done <= 1'b1;
          use_ext  <= ext_sel;
          osc_oe   <= ~ext_sel;
        end else begin
          ptr <= ptr + IDX_W'(1);
        end
      end
      if (sel_e.rise) hold_stb <= 1'b1;
    end
  end
endmodule

// File: rtl/rseq_chk.sv
module rseq_chk #(
  parameter int NUM_CH = 12,
  parameter int CODE_W = 10,
  parameter int STEP   = 128,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  ch_idx,
  input logic [CODE_W-1:0] ch_code,
  input logic              sample_stb,
  input logic              hold_stb,
  input logic              rot_done,
  input logic              osc_oe
);
  logic [IDX_W-1:0]  last_idx;
  logic              seen;
  logic [CODE_W-1:0] prev_code [NUM_CH];
  logic [CODE_W-1:0] pc;
  logic [CODE_W:0]   moved;
  logic [IDX_W-1:0]  want_idx;

  assign pc       = prev_code[ch_idx];
  assign moved    = (ch_code >= pc) ? {1'b0, ch_code - pc} : {1'b0, pc - ch_code};
  assign want_idx = (last_idx == IDX_W'(NUM_CH - 1)) ? '0 : last_idx + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx <= '0;
      seen     <= 1'b0;
      for (int k = 0; k < NUM_CH; k++) prev_code[k] <= '0;
    end else if (sample_stb) begin
      last_idx          <= ch_idx;
      seen              <= 1'b1;
      prev_code[ch_idx] <= ch_code;
    end
  end

  // R1
  rr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && seen) |-> (ch_idx == want_idx));
  // R1
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !seen) |-> (ch_idx == '0));
  // R2
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && hold_stb));
  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (moved <= (CODE_W+1)'(STEP)));
  // R5
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_done |-> (sample_stb && ch_idx == IDX_W'(NUM_CH - 1)));
  // R8
  oe_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_done |-> $stable(osc_oe));
endmodule

bind ref_refresh_seq rseq_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .STEP(STEP), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_idx(ch_idx), .ch_code(ch_code),
  .sample_stb(sample_stb), .hold_stb(hold_stb), .rot_done(rot_done),
  .osc_oe(osc_oe)
);

// File: tb/ref_refresh_seq_tb_top.sv
module ref_refresh_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC         = 4;
  localparam int CW         = 10;
  localparam int STEP       = 128;
  localparam int HALF       = 3;
  localparam int EXT_HALF   = 5;
  localparam int IW         = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NC*CW-1:0] tgt_bus;
  logic            ext_sel;
  logic            ext_clk_in = 1'b0;
  logic            osc_out, osc_oe, sample_stb, hold_stb, rot_done;
  logic [IW-1:0]   ch_idx;
  logic [CW-1:0]   ch_code;

  int checks = 0;
  int fails  = 0;
  int tgt_m  [NC];
  int pres_m [NC];
  int exp_idx  [$];
  int exp_code [$];
  int gap_cnt = 0;
  int last_gap = 0;
  int holds = 0;
  int n_samples = 0;

  ref_refresh_seq #(.NUM_CH(NC), .CODE_W(CW), .STEP(STEP), .TICK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .target_codes(tgt_bus), .ext_sel(ext_sel),
    .ext_clk_in(ext_clk_in), .osc_out(osc_out), .osc_oe(osc_oe),
    .ch_idx(ch_idx), .ch_code(ch_code), .sample_stb(sample_stb),
    .hold_stb(hold_stb), .rot_done(rot_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (EXT_HALF) @(negedge clk);
      ext_clk_in = ~ext_clk_in;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_step(input int cur, input int tgt);
    if (tgt - cur > STEP) return cur + STEP;
    if (cur - tgt > STEP) return cur - STEP;
    return tgt;
  endfunction

  task automatic set_targets(input int a, input int b, input int c, input int d);
    tgt_m[0] = a; tgt_m[1] = b; tgt_m[2] = c; tgt_m[3] = d;
    for (int k = 0; k < NC; k++) tgt_bus[k*CW +: CW] = CW'(tgt_m[k]);
  endtask

  // Driver: expected slot items for n rotations (R3, R4, R9)
  task automatic push_rotations(input int n);
    for (int r = 0; r < n; r++)
      for (int c = 0; c < NC; c++) begin
        pres_m[c] = model_step(pres_m[c], tgt_m[c]);
        exp_idx.push_back(c);
        exp_code.push_back(pres_m[c]);
      end
  endtask

  task automatic wait_rots(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (rot_done) k++;
    end
  endtask

  task automatic wait_samples(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (sample_stb) k++;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      gap_cnt++;
      if (hold_stb) holds++;
      if (sample_stb) begin
        n_samples++;
        last_gap = gap_cnt;
        gap_cnt  = 0;
        if (exp_idx.size() == 0) begin
          chk(1'b0, "R1 unexpected slot", int'(ch_idx), -1);
        end else begin
          int ei, ec;
          ei = exp_idx.pop_front();
          ec = exp_code.pop_front();
          chk(int'(ch_idx) == ei, "R1 channel order", int'(ch_idx), ei);
          chk(int'(ch_code) == ec, "R3/R4 presented code", int'(ch_code), ec);
        end
        // R5
        chk(rot_done == (ch_idx == IW'(NC-1)), "R5 rotation pulse", int'(rot_done), int'(ch_idx == IW'(NC-1)));
        // R2: one hold between slots inside a rotation
        if (n_samples > 1 && ch_idx != '0)
          chk(holds == 1, "R2 holds between slots", holds, 1);
        holds = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    ext_sel = 1'b0;
    for (int k = 0; k < NC; k++) pres_m[k] = 0;
    set_targets(700, 3, 1023, 0);
    repeat (4) @(negedge clk);
    // R6 reset state
    chk(ch_idx == '0, "R6 idx", int'(ch_idx), 0);
    chk(ch_code == '0, "R6 code", int'(ch_code), 0);
    chk(!sample_stb && !hold_stb && !rot_done, "R6 strobes", int'(sample_stb), 0);
    chk(osc_oe == 1'b0, "R6 pin enable", int'(osc_oe), 0);
    push_rotations(6);
    rst_n = 1'b1;
    @(negedge clk);
    chk(osc_oe == 1'b0, "R6 pin enable after reset", int'(osc_oe), 0);
    wait_rots(1);
    @(negedge clk);
    chk(osc_oe == 1'b1, "R8 pin driven with internal source", int'(osc_oe), 1);
    wait_rots(5);
    chk(last_gap == 2*HALF, "R7 internal spacing", last_gap, 2*HALF);

    // New targets on a boundary: small exact, large stepped both ways (R4, R9)
    set_targets(5, 900, 300, 129);
    push_rotations(8);
    wait_rots(8);

    // Source switch requested mid-rotation (R8)
    push_rotations(4);
    fork
      wait_rots(4);
      begin
        wait_samples(2);
        ext_sel = 1'b1;
        @(negedge clk);
        chk(osc_oe == 1'b1, "R8 no change mid-rotation", int'(osc_oe), 1);
        wait_samples(1);
        chk(last_gap == 2*HALF, "R8 old source kept", last_gap, 2*HALF);
      end
    join
    @(negedge clk);
    chk(osc_oe == 1'b0, "R8 pin released for external", int'(osc_oe), 0);
    push_rotations(2);
    wait_rots(2);
    chk(last_gap == 2*EXT_HALF, "R7 external spacing", last_gap, 2*EXT_HALF);

    ext_sel = 1'b0;
    push_rotations(2);
    wait_rots(2);
    @(negedge clk);
    chk(osc_oe == 1'b1, "R8 back to internal", int'(osc_oe), 1);
    chk(last_gap == 2*HALF, "R7 internal spacing again", last_gap, 2*HALF);
    @(negedge clk);
    chk(exp_idx.size() == 0, "R1 all slots seen", exp_idx.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule